// File: doc/BRIEF.md
# SPI Flash Program and Erase Sequencer

This block sits on the host side of a serial NOR flash and runs its modify operations from start to finish. A client hands it one request at a time: a page program, a sector erase or a bulk erase. For each request the sequencer sends a stand-alone write-enable frame. It then sends the command frame with its address and, for a program, the data bytes. The data bytes are fetched from a client-side buffer through an index/data port. Finally the sequencer holds the flash selected while it reads the status byte again and again, and it stops when the busy flag clears.

The SPI bus runs in mode 0: SCK idles low, the flash samples MOSI on the rising edge and the host samples MISO on the rising edge. The SCK half period is set at run time from the system clock. A program burst that would cross a page boundary, or that has an illegal length, is refused and nothing is driven on the bus. A flash that stays busy longer than the poll limit ends the operation with an error. Each operation ends with a one-cycle completion pulse, and an error flag is valid in the same cycle.

Top module: `flash_seq`

## Requirements
- R1: After reset, spiCsN is 1, spiSck is 0, and both done and reqAck are 0.
- R2: A request is accepted only while the sequencer is idle. Acceptance gives one reqAck pulse. A request held high while an operation is running gets no reqAck until that operation has finished.
- R3: Every accepted program or erase starts with a frame that holds exactly one byte, 06h. Chip select is raised after that frame and stays high for at least one cycle before the command frame begins.
- R4: A program (reqOp=0) sends one frame: 02h, then the 3 address bytes with the most significant byte first, then reqLen data bytes. Data byte i is the value returned on bufData while bufIdx=i, for i = 0 to reqLen-1. Every byte goes out MSB first.
- R5: A sector erase (reqOp=1) sends a 4-byte frame: D8h followed by the 3 address bytes, most significant byte first. A bulk erase (reqOp=2) sends a frame holding the single byte C7h.
- R6: A program request is refused when reqLen is 0, when reqLen is greater than 256, or when (reqAddr[7:0] + reqLen) is greater than 256. A refused request is acknowledged, then done and err are raised together and no SPI frame is sent. A length that ends exactly on a page boundary is accepted.
- R7: After the command frame, the sequencer sends one frame made of 05h followed by status bytes. It keeps chip select low between status bytes. It ends the frame at the first status byte whose bit 0 is 0, and then raises done with err at 0.
- R8: If MAX_POLLS status bytes in a row all have bit 0 set to 1, the sequencer ends the status frame after the last of them and raises done with err at 1. Chip select is high in the cycle that done is high.
- R9: SCK stays low whenever chip select is high. Each SCK high phase lasts exactly sckHalf+1 system clocks. MOSI does not change at a rising SCK edge. Every frame carries a whole number of bytes.
- R10: done is high for exactly one cycle per operation.
- R11: reqOp=3 is refused in the same way as a bad program: done and err are raised and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 invalid |
| reqAddr | input | 24 | Flash byte address |
| reqLen | input | 9 | Program byte count (1 to 256) |
| reqAck | output | 1 | One-cycle pulse when a request is taken |
| bufIdx | output | 8 | Index of the program byte to be sent next |
| bufData | input | 8 | Buffer byte at bufIdx |
| sckHalf | input | 8 | SCK half period minus one, in system clocks |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | SPI clock |
| spiMosi | output | 1 | Data from host to flash |
| spiMiso | input | 1 | Data from flash to host |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error qualifier, valid while done is high |

## Verification
The bench builds the sequencer with MAX_POLLS=8 and GAP_CYC=2, and keeps the page size and the address width at their defaults. The small poll limit means the flash model can reach the timeout in a few hundred cycles: 7 busy reads still end cleanly, while 8 busy reads end in an error. Because the page size is the real 256 bytes, a full-page burst and the one-byte page crossings are both exercised. The SCK divider is varied between 0 and 2, which covers both the fastest SCK and a stretched one.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BULK = 2'd2,
    OP_NONE = 2'd3
  } flashOp_t;

  localparam logic [7:0] CMD_WEN  = 8'h06;
  localparam logic [7:0] CMD_PROG = 8'h02;
  localparam logic [7:0] CMD_SECT = 8'hD8;
  localparam logic [7:0] CMD_BULK = 8'hC7;
  localparam logic [7:0] CMD_STAT = 8'h05;

  // strobes from control to the shift datapath
  typedef struct packed {
    logic       launch;
    logic [7:0] txByte;
  } dpCtl_t;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [DIV_W-1:0] sckHalf,
  input  logic             spiMiso,
  output logic             spiSck,
  output logic             spiMosi,
  output logic             byteDone,
  output logic [7:0]       rxByte
);

  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;
  logic             active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      bitCnt   <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      active   <= 1'b0;
      spiSck   <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (ctl.launch) begin
        txSh   <= ctl.txByte;
        bitCnt <= '0;
        divCnt <= '0;
        active <= 1'b1;
        spiSck <= 1'b0;
      end else if (active) begin
        if (divCnt == sckHalf) begin
          divCnt <= '0;
          if (!spiSck) begin
            spiSck <= 1'b1;
            rxSh   <= {rxSh[6:0], spiMiso};
          end else begin
            spiSck <= 1'b0;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign spiMosi = active & txSh[7];
  assign rxByte  = rxSh;

  // control never starts a byte while one is still shifting
  p_no_relaunch_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.launch |-> !active);

  // mode 0: data is settled before the rising edge
  p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSck) |-> $stable(spiMosi));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_BYTES = 3,
  parameter int MAX_POLLS  = 4096,
  parameter int GAP_CYC    = 4,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int LEN_W     = PAGE_W + 1,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqAck,
  output logic [PAGE_W-1:0] bufIdx,
  input  logic [7:0]        bufData,
  output dpCtl_t            ctl,
  input  logic              byteDone,
  input  logic [7:0]        rxByte,
  output logic              spiCsN,
  output logic              done,
  output logic              err
);

  localparam int IDX_W    = LEN_W + 1;
  localparam int DATA_IDX = ADDR_BYTES + 1;
  localparam int POLL_W   = $clog2(MAX_POLLS + 1);
  localparam int GAP_W    = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WAIT, S_GAP, S_DONE} state_t;
  typedef enum logic [1:0] {PH_WREN, PH_CMD, PH_POLL} phase_t;

  state_t            state;
  phase_t            phase;
  flashOp_t          opR;
  logic [ADDR_W-1:0] addrR;
  logic [LEN_W-1:0]  lenR;
  logic [IDX_W-1:0]  idx;
  logic [POLL_W-1:0] pollCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic              errR;
  logic              ackR;
  logic              badReq;
  logic [LEN_W:0]    pageEnd;
  logic [IDX_W-1:0]  lastIdx;
  logic [ADDR_W-1:0] addrSh;
  logic [7:0]        opCode;
  logic [7:0]        txSel;

  // request screening: page containment and legal opcode
  always_comb begin
    pageEnd = (LEN_W+1)'(reqAddr[PAGE_W-1:0]) + (LEN_W+1)'(reqLen);
    badReq  = (reqOp == OP_NONE) ||
              ((reqOp == OP_PROG) &&
               ((reqLen == '0) || (32'(reqLen) > PAGE_BYTES) || (32'(pageEnd) > PAGE_BYTES)));
  end

  always_comb begin
    unique case (opR)
      OP_PROG: begin opCode = CMD_PROG; lastIdx = IDX_W'(ADDR_BYTES) + IDX_W'(lenR); end
      OP_SECT: begin opCode = CMD_SECT; lastIdx = IDX_W'(ADDR_BYTES); end
      default: begin opCode = CMD_BULK; lastIdx = '0; end
    endcase
    if (phase == PH_WREN) lastIdx = '0;
  end

  // byte to send for the current frame position
  always_comb begin
    addrSh = addrR >> (8 * (ADDR_BYTES - 32'(idx)));
    txSel  = 8'h00;
    unique case (phase)
      PH_WREN: txSel = CMD_WEN;
      PH_CMD: begin
        if (idx == '0)                  txSel = opCode;
        else if (32'(idx) < DATA_IDX)   txSel = addrSh[7:0];
        else                            txSel = bufData;
      end
      default: txSel = (idx == '0) ? CMD_STAT : 8'h00;
    endcase
  end

  assign bufIdx     = PAGE_W'(idx - IDX_W'(DATA_IDX));
  assign ctl.launch = (state == S_LOAD);
  assign ctl.txByte = txSel;
  assign done       = (state == S_DONE);
  assign err        = (state == S_DONE) & errR;
  assign reqAck     = ackR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= PH_WREN;
      opR     <= OP_PROG;
      addrR   <= '0;
      lenR    <= '0;
      idx     <= '0;
      pollCnt <= '0;
      gapCnt  <= '0;
      errR    <= 1'b0;
      ackR    <= 1'b0;
      spiCsN  <= 1'b1;
    end else begin
      ackR <= 1'b0;
      unique case (state)
        S_IDLE: if (reqValid) begin
          ackR    <= 1'b1;
          opR     <= flashOp_t'(reqOp);
          addrR   <= reqAddr;
          lenR    <= reqLen;
          idx     <= '0;
          pollCnt <= '0;
          phase   <= PH_WREN;
          errR    <= badReq;
          state   <= badReq ? S_DONE : S_LOAD;
        end
        S_LOAD: begin
          spiCsN <= 1'b0;
          state  <= S_WAIT;
        end
        S_WAIT: if (byteDone) begin
          if (phase == PH_POLL && idx != '0) begin
            if (!rxByte[0]) begin
              spiCsN <= 1'b1;
              errR   <= 1'b0;
              state  <= S_DONE;
            end else if (32'(pollCnt) == MAX_POLLS - 1) begin
              spiCsN <= 1'b1;
              errR   <= 1'b1;
              state  <= S_DONE;
            end else begin
              pollCnt <= pollCnt + 1'b1;
              state   <= S_LOAD;
            end
          end else if (phase != PH_POLL && idx == lastIdx) begin
            spiCsN <= 1'b1;
            gapCnt <= '0;
            phase  <= (phase == PH_WREN) ? PH_CMD : PH_POLL;
            state  <= S_GAP;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_LOAD;
          end
        end
        S_GAP: begin
          if (32'(gapCnt) == GAP_CYC - 1) begin
            idx   <= '0;
            state <= S_LOAD;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_cs_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> spiCsN);

  p_single_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_POLL) |-> (32'(pollCnt) < MAX_POLLS));

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_BYTES = 3,
  parameter int MAX_POLLS  = 4096,
  parameter int GAP_CYC    = 4,
  parameter int DIV_W      = 8,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int LEN_W     = PAGE_W + 1,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqAck,
  output logic [PAGE_W-1:0] bufIdx,
  input  logic [7:0]        bufData,
  input  logic [DIV_W-1:0]  sckHalf,
  output logic              spiCsN,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              done,
  output logic              err
);

  dpCtl_t     ctl;
  logic       byteDone;
  logic [7:0] rxByte;

  flash_seq_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .ADDR_BYTES(ADDR_BYTES),
    .MAX_POLLS(MAX_POLLS), .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqAck(reqAck), .bufIdx(bufIdx), .bufData(bufData),
    .ctl(ctl), .byteDone(byteDone), .rxByte(rxByte),
    .spiCsN(spiCsN), .done(done), .err(err)
  );

  flash_seq_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sckHalf(sckHalf),
    .spiMiso(spiMiso), .spiSck(spiSck), .spiMosi(spiMosi),
    .byteDone(byteDone), .rxByte(rxByte)
  );

  p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);

endmodule

// File: tb/flash_seq_test.sv
`timescale 1ns/1ps
module flash_seq_test;

  localparam int MAXP = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [23:0] reqAddr = '0;
  logic [8:0]  reqLen = '0;
  logic        reqAck;
  logic [7:0]  bufIdx;
  logic [7:0]  bufData;
  logic [7:0]  sckHalf = 8'd1;
  logic        spiCsN, spiSck, spiMosi, spiMiso;
  logic        done, err;

  int nChk = 0;
  int nFail = 0;

  logic [7:0] bufMem [256];
  assign bufData = bufMem[bufIdx];

  always #2 clk = ~clk;

  flash_seq #(.MAX_POLLS(MAXP), .GAP_CYC(2)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqAck(reqAck),
    .bufIdx(bufIdx), .bufData(bufData), .sckHalf(sckHalf),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .done(done), .err(err)
  );

  // ---------------- flash model ----------------
  int         bitCnt = 0;
  logic [7:0] inSh;
  logic [7:0] fb [4][264];
  int         fl [4];
  int         nFrames = 0;
  int         busyLeft = 0;
  int         busySet = 0;
  int         partialBad = 0;

  assign spiMiso = (bitCnt % 8 == 7) && (bitCnt >= 8) && (busyLeft > 0);

  always @(posedge spiSck) if (spiCsN === 1'b0) begin
    inSh = {inSh[6:0], spiMosi};
    bitCnt++;
    if (bitCnt % 8 == 0) begin
      if (nFrames < 4 && bitCnt / 8 <= 264) fb[nFrames][bitCnt/8-1] = inSh;
      if (nFrames < 4 && fb[nFrames][0] == 8'h05 && bitCnt / 8 >= 2 && busyLeft > 0)
        busyLeft--;
    end
  end

  always @(posedge spiCsN) begin
    if (bitCnt > 0) begin
      if (bitCnt % 8 != 0) partialBad++;
      if (nFrames < 4) begin
        fl[nFrames] = bitCnt / 8;
        if (fb[nFrames][0] != 8'h05 && fb[nFrames][0] != 8'h06) busyLeft = busySet;
      end
      nFrames++;
    end
    bitCnt = 0;
  end

  // ---------------- monitors ----------------
  int ackCnt = 0, doneBad = 0, sckBad = 0, hiRun = 0;
  logic prevDone = 1'b0;
  always @(negedge clk) if (rstN) begin
    if (reqAck) ackCnt++;
    if (done && prevDone) doneBad++;
    prevDone = done;
    if (spiSck && spiCsN) sckBad++;
    if (spiSck) hiRun++;
    else if (hiRun > 0) begin
      if (hiRun != int'(sckHalf) + 1) sckBad++;
      hiRun = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit isBad(input logic [1:0] op, input logic [23:0] a, input int len);
    if (op == 2'd3) return 1'b1;
    if (op != 2'd0) return 1'b0;
    return (len < 1) || (len > 256) || (int'(a[7:0]) + len > 256);
  endfunction

  function automatic int expPolls(input int busyN);
    return (busyN + 1 > MAXP) ? MAXP : busyN + 1;
  endfunction

  task automatic runOp(input logic [1:0] op, input logic [23:0] a, input int len,
                       input int busyN, input bit holdExtra);
    bit bad, gotErr;
    int dataBad;
    int cmdLen;
    logic [7:0] opc;
    bad = isBad(op, a, len);
    for (int i = 0; i < 256; i++) bufMem[i] = 8'($urandom);
    busySet = busyN; nFrames = 0; ackCnt = 0; doneBad = 0; sckBad = 0; partialBad = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqLen = 9'(len);
    while (!reqAck) @(negedge clk);
    reqValid = 1'b0;
    if (holdExtra) begin
      reqValid = 1'b1; reqOp = 2'd2;
      repeat (20) @(negedge clk);
      reqValid = 1'b0;
      chk(ackCnt == 1, "R2 no ack while busy", ackCnt, 1);
    end
    while (!done) @(negedge clk);
    gotErr = err;
    repeat (4) @(negedge clk);
    chk(ackCnt == 1, "R2 one ack per request", ackCnt, 1);
    chk(doneBad == 0, "R10 done one cycle", doneBad, 0);
    chk(sckBad == 0 && partialBad == 0, "R9 sck framing", sckBad + partialBad, 0);
    if (bad) begin
      chk(gotErr == 1'b1, (op == 2'd3) ? "R11 bad op err" : "R6 reject err", gotErr, 1);
      chk(nFrames == 0, (op == 2'd3) ? "R11 no frames" : "R6 no frames", nFrames, 0);
      return;
    end
    chk(nFrames == 3, "R3 frame count", nFrames, 3);
    if (nFrames != 3) return;
    chk(fl[0] == 1 && fb[0][0] == 8'h06, "R3 write enable frame", {fl[0], 8'(fb[0][0])}, 16'h0106);
    opc    = (op == 2'd0) ? 8'h02 : (op == 2'd1) ? 8'hD8 : 8'hC7;
    cmdLen = (op == 2'd0) ? 4 + len : (op == 2'd1) ? 4 : 1;
    chk(fb[1][0] == opc, (op == 2'd0) ? "R4 opcode" : "R5 opcode", fb[1][0], opc);
    chk(fl[1] == cmdLen, (op == 2'd0) ? "R4 frame len" : "R5 frame len", fl[1], cmdLen);
    if (op != 2'd2)
      chk({fb[1][1], fb[1][2], fb[1][3]} == a, (op == 2'd0) ? "R4 address" : "R5 address",
          {fb[1][1], fb[1][2], fb[1][3]}, a);
    if (op == 2'd0) begin
      dataBad = 0;
      for (int i = 0; i < len && i < 256; i++) if (fb[1][4+i] != bufMem[i]) dataBad++;
      chk(dataBad == 0, "R4 data bytes", dataBad, 0);
    end
    chk(fb[2][0] == 8'h05, "R7 status opcode", fb[2][0], 8'h05);
    chk(fl[2] == 1 + expPolls(busyN), "R7 poll count", fl[2], 1 + expPolls(busyN));
    chk(gotErr == (busyN + 1 > MAXP), (busyN + 1 > MAXP) ? "R8 timeout err" : "R7 clean done",
        gotErr, busyN + 1 > MAXP);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog act=hung exp=complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(spiCsN == 1'b1 && spiSck == 1'b0 && done == 1'b0 && reqAck == 1'b0,
        "R1 reset state", {spiCsN, spiSck, done, reqAck}, 4'b1000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(spiCsN == 1'b1 && done == 1'b0, "R1 idle after reset", {spiCsN, done}, 2'b10);

    // directed corners
    sckHalf = 8'd0;
    runOp(2'd0, 24'h012300, 256, 2, 1'b0);   // R4 full page
    runOp(2'd0, 24'h0100FF, 1, 0, 1'b0);     // R6 last byte of page is legal
    runOp(2'd0, 24'h0000FF, 2, 0, 1'b0);     // R6 crossing
    runOp(2'd0, 24'h000010, 0, 0, 1'b0);     // R6 zero length
    runOp(2'd0, 24'h000000, 257, 0, 1'b0);   // R6 too long
    runOp(2'd3, 24'h000000, 4, 0, 1'b0);     // R11 invalid op
    sckHalf = 8'd2;
    runOp(2'd1, 24'hA5C31E, 0, 3, 1'b1);     // R5 sector erase, R2 hold, R9 divider
    runOp(2'd2, 24'h000000, 0, 7, 1'b0);     // R5 bulk erase, R7 last legal poll
    sckHalf = 8'd1;
    runOp(2'd1, 24'h030000, 0, 8, 1'b0);     // R8 timeout
    runOp(2'd0, 24'h7F0080, 128, 20, 1'b0);  // R8 timeout after program

    // constrained random mix
    for (int n = 0; n < 24; n++) begin
      logic [1:0]  rop;
      logic [23:0] ra;
      int          rl;
      rop = 2'($urandom_range(0, 3));
      ra  = 24'($urandom);
      rl  = $urandom_range(1, 64);
      if ($urandom_range(0, 3) == 0) ra[7:0] = 8'(256 - rl + $urandom_range(0, 1));
      sckHalf = 8'($urandom_range(0, 1));
      runOp(rop, ra, rl, $urandom_range(0, 9), 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule